// File: doc/BRIEF.md
# Phase-Synchronized PWM Time Base

This block is one channel of a phase-shifted full-bridge drive. An up-counting time base runs from 0 to `period_i - 1` and wraps. A sync pulse from an upstream channel can reload the counter with a programmable phase value. Two chained instances therefore run at the same frequency with a controlled phase offset between them. The block drives a complementary pair of legs at fixed 50% duty. Each leg has its own programmable dead band on its rising edge, so the two legs are never on together.

A sync output lets instances be daisy-chained. Its source is selected at run time from four events:
- counter zero,
- the incoming sync (pass-through),
- counter equal to a compare value,
- a software strobe.

The phase value is held in a register that a slow control loop may rewrite at any time. The counter only picks up the new value on the next sync pulse. In a chain, the sync output is registered and the downstream load is registered as well. With zero-source sync, the downstream counter shows `phase - 2` relative to the upstream counter.

Top module: `pwm_phase_chan`

## Requirements
- R1: While `rst_n` is low, `cnt_o` is 0 and `pwm_a_o`, `pwm_b_o` and `sync_o` are all low.
- R2: With no sync load, `cnt_o` steps by one each clock from 0 up to `period_i - 1` and then returns to 0 (`period_i` ≥ 2). If the count is already at or above `period_i - 1`, the next value is 0.
- R3: When `sync_i` and `phase_en_i` are both high in a cycle, `cnt_o` equals the phase register in the next cycle and counts up from there.
- R4: When `phase_en_i` is low, a pulse on `sync_i` has no effect on `cnt_o`.
- R5: A high `phase_wr_i` stores `phase_wdata_i` into the phase register at the clock edge.
  - The stored value reaches the counter only on a later sync load; the write never changes the running count.
  - A write in the same cycle as a sync load lets the load use the old value.
- R6: `sync_o` is a registered one-clock pulse, high in the cycle after the selected event. The `sync_sel_i` codes are:
  - 0: `cnt_o` == 0
  - 1: `sync_i` high (pass-through)
  - 2: `cnt_o` == `cmp_i`
  - 3: `sw_sync_i` high
- R7: The raw A leg is high while `cnt_o` < `period_i >> 1`, and the raw B leg is its complement. The outputs follow the raw legs one clock later.
- R8: A rising edge of the A output is delayed by `rise_dly_i` further clocks, and a rising edge of the B output by `fall_dly_i` further clocks. Falling edges are not delayed, so both outputs are low during the dead interval and are never high together.
- R9: With a phase of 0, a sync load that arrives while the count is at `period_i - 1` gives 0 and then 1, with no discontinuity.
- R10: A loaded phase at or above `period_i - 1` is shown for one clock, and the counter then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_i | input | CNT_W | Counts per PWM cycle |
| phase_wr_i | input | 1 | Write strobe for the phase register |
| phase_wdata_i | input | CNT_W | New phase value, in clocks |
| phase_en_i | input | 1 | Allow sync pulses to load the counter |
| sync_i | input | 1 | Sync pulse from the upstream channel |
| sw_sync_i | input | 1 | One-cycle software sync strobe |
| sync_sel_i | input | 2 | Sync output source (0 zero, 1 pass, 2 compare, 3 software) |
| cmp_i | input | CNT_W | Compare value for sync source 2 |
| rise_dly_i | input | DB_W | Dead band before the A output rises |
| fall_dly_i | input | DB_W | Dead band before the B output rises |
| cnt_o | output | CNT_W | Current counter value |
| sync_o | output | 1 | Sync pulse to the downstream channel |
| pwm_a_o | output | 1 | A leg output |
| pwm_b_o | output | 1 | B leg output |

## Verification
The embedded assertions check the following on every clock:
- the counter steps by one between loads;
- a sync load puts the previous phase register value into the counter;
- pass-through sync appears one clock later;
- the legs are never high together, and each output is high only if its raw leg was high the clock before.

The exact dead-band lengths, the same-cycle write and load ordering, the wrap-point load with zero phase, and out-of-range phases are shown only by the bench's scenarios. These scenarios are checked against a cycle model built from the requirements.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

    // Sync output source codes
    typedef enum logic [1:0] {
        SO_ZERO = 2'd0,
        SO_PASS = 2'd1,
        SO_CMP  = 2'd2,
        SO_SW   = 2'd3
    } sync_src_e;

endpackage

// File: rtl/pwm_tbase.sv
module pwm_tbase
    import pwm_phase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic             phase_wr_i,
    input  logic [CNT_W-1:0] phase_wdata_i,
    input  logic             phase_en_i,
    input  logic             sync_i,
    input  logic             sw_sync_i,
    input  logic [1:0]       sync_sel_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sync_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] phase;
        logic             sync;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      load;
    logic      at_top;
    sync_src_e src;

    assign src    = sync_src_e'(sync_sel_i);
    assign load   = sync_i && phase_en_i;
    assign at_top = (st_q.cnt >= (period_i - ONE));

    always_comb begin
        st_d = st_q;

        // Counter: a sync load wins over the normal count and wrap
        if (load) begin
            st_d.cnt = st_q.phase;
        end else if (at_top) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end

        // Shadow phase register; it is only used by the next load
        if (phase_wr_i) begin
            st_d.phase = phase_wdata_i;
        end

        // Sync output event select
        unique case (src)
            SO_ZERO: st_d.sync = (st_q.cnt == '0);
            SO_PASS: st_d.sync = sync_i;
            SO_CMP:  st_d.sync = (st_q.cnt == cmp_i);
            SO_SW:   st_d.sync = sw_sync_i;
            default: st_d.sync = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign sync_o = st_q.sync;

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (cnt_o < (period_i - ONE))) |=> (cnt_o == $past(cnt_o) + ONE));

    // R3
    phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_o == $past(st_q.phase)));

    // R6
    sync_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src == SO_PASS) && sync_i) |=> sync_o);

endmodule

// File: rtl/pwm_leg.sv
module pwm_leg #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_i,
    input  logic [DB_W-1:0] dly_i,
    output logic            out_o
);

    localparam logic [DB_W-1:0] RUN_MAX = {DB_W{1'b1}};
    localparam logic [DB_W-1:0] ONE     = {{(DB_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DB_W-1:0] run;
        logic            out;
    } leg_state_t;

    leg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // Saturating count of consecutive clocks with the raw leg high
        if (!raw_i) begin
            st_d.run = '0;
        end else if (st_q.run != RUN_MAX) begin
            st_d.run = st_q.run + ONE;
        end

        // The output turns on only after the dead band has elapsed
        st_d.out = raw_i && (st_q.run >= dly_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    // R7
    out_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_o) |-> $past(raw_i));

endmodule

// File: rtl/pwm_phase_chan.sv
module pwm_phase_chan
    import pwm_phase_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DB_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic             phase_wr_i,
    input  logic [CNT_W-1:0] phase_wdata_i,
    input  logic             phase_en_i,
    input  logic             sync_i,
    input  logic             sw_sync_i,
    input  logic [1:0]       sync_sel_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [DB_W-1:0]  rise_dly_i,
    input  logic [DB_W-1:0]  fall_dly_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sync_o,
    output logic             pwm_a_o,
    output logic             pwm_b_o
);

    localparam int NLEG = 2;

    logic [CNT_W-1:0] half;
    logic [NLEG-1:0]  raw;
    logic [NLEG-1:0]  leg_out;
    logic [DB_W-1:0]  leg_dly [NLEG];

    pwm_tbase #(.CNT_W(CNT_W)) tbase_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .period_i      (period_i),
        .phase_wr_i    (phase_wr_i),
        .phase_wdata_i (phase_wdata_i),
        .phase_en_i    (phase_en_i),
        .sync_i        (sync_i),
        .sw_sync_i     (sw_sync_i),
        .sync_sel_i    (sync_sel_i),
        .cmp_i         (cmp_i),
        .cnt_o         (cnt_o),
        .sync_o        (sync_o)
    );

    // Fixed 50% duty: A is high for the first half of the period, B is its complement
    assign half       = period_i >> 1;
    assign raw[0]     = (cnt_o < half);
    assign raw[1]     = ~raw[0];
    assign leg_dly[0] = rise_dly_i;
    assign leg_dly[1] = fall_dly_i;

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        pwm_leg #(.DB_W(DB_W)) leg_i (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw[g]),
            .dly_i (leg_dly[g]),
            .out_o (leg_out[g])
        );
    end

    assign pwm_a_o = leg_out[0];
    assign pwm_b_o = leg_out[1];

    // R8
    legs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_a_o && pwm_b_o));

endmodule

// File: tb/pwm_phase_chan_tb.sv
module pwm_phase_chan_tb_top;

    localparam int CNT_W = 16;
    localparam int DB_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] period_i = 16'd10;
    logic             phase_wr_i = 1'b0;
    logic [CNT_W-1:0] phase_wdata_i = '0;
    logic             phase_en_i = 1'b0;
    logic             sync_i = 1'b0;
    logic             sw_sync_i = 1'b0;
    logic [1:0]       sync_sel_i = 2'd0;
    logic [CNT_W-1:0] cmp_i = '0;
    logic [DB_W-1:0]  rise_dly_i = '0;
    logic [DB_W-1:0]  fall_dly_i = '0;
    logic [CNT_W-1:0] cnt_o;
    logic             sync_o;
    logic             pwm_a_o;
    logic             pwm_b_o;

    int vecs = 0;
    int miss = 0;
    bit done = 1'b0;

    // Reference model state
    int m_cnt = 0, m_phase = 0, m_run_a = 0, m_run_b = 0;
    bit m_sync = 0, m_a = 0, m_b = 0;

    always #5 clk = ~clk;

    pwm_phase_chan #(.CNT_W(CNT_W), .DB_W(DB_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .period_i      (period_i),
        .phase_wr_i    (phase_wr_i),
        .phase_wdata_i (phase_wdata_i),
        .phase_en_i    (phase_en_i),
        .sync_i        (sync_i),
        .sw_sync_i     (sw_sync_i),
        .sync_sel_i    (sync_sel_i),
        .cmp_i         (cmp_i),
        .rise_dly_i    (rise_dly_i),
        .fall_dly_i    (fall_dly_i),
        .cnt_o         (cnt_o),
        .sync_o        (sync_o),
        .pwm_a_o       (pwm_a_o),
        .pwm_b_o       (pwm_b_o)
    );

    // Next count per R2, R3, R10
    function automatic int exp_cnt(int cur, int per, int ph, bit ld);
        if (ld) return ph;
        if (cur >= per - 1) return 0;
        return cur + 1;
    endfunction

    // Sync output event per R6
    function automatic bit exp_sync(int sel, int cur, bit si, int cmp, bit sw);
        case (sel)
            0: return cur == 0;
            1: return si;
            2: return cur == cmp;
            default: return sw;
        endcase
    endfunction

    function automatic int sat_inc(int v, bit raw);
        if (!raw) return 0;
        return (v >= 255) ? 255 : v + 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_phase <= 0; m_sync <= 0;
            m_a <= 0; m_b <= 0; m_run_a <= 0; m_run_b <= 0;
        end else begin
            bit ra;
            ra = m_cnt < (int'(period_i) / 2);
            m_cnt   <= exp_cnt(m_cnt, int'(period_i), m_phase, sync_i && phase_en_i);
            m_phase <= phase_wr_i ? int'(phase_wdata_i) : m_phase;
            m_sync  <= exp_sync(int'(sync_sel_i), m_cnt, sync_i, int'(cmp_i), sw_sync_i);
            m_a     <= ra && (m_run_a >= int'(rise_dly_i));
            m_b     <= !ra && (m_run_b >= int'(fall_dly_i));
            m_run_a <= sat_inc(m_run_a, ra);
            m_run_b <= sat_inc(m_run_b, !ra);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            miss++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock, then a full comparison against the model away from the edge
    task automatic step();
        @(negedge clk);
        chk("R2 R3 R4 R5 R9 R10 count", int'(cnt_o), m_cnt);
        chk("R6 sync_o", int'(sync_o), int'(m_sync));
        chk("R7 R8 leg A", int'(pwm_a_o), int'(m_a));
        chk("R7 R8 leg B", int'(pwm_b_o), int'(m_b));
    endtask

    task automatic write_phase(input int v);
        phase_wr_i = 1'b1; phase_wdata_i = CNT_W'(v);
        step();
        phase_wr_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cnt in reset", int'(cnt_o), 0);
        chk("R1 outputs in reset", int'({pwm_a_o, pwm_b_o, sync_o}), 0);
        rst_n = 1'b1;
        repeat (25) step();

        // R9: zero phase loaded at the wrap point
        period_i = 16'd10; phase_en_i = 1'b1;
        write_phase(0);
        for (int i = 0; i < 20 && cnt_o != 16'd9; i++) step();
        sync_i = 1'b1; step(); sync_i = 1'b0;
        chk("R9 wrap load", int'(cnt_o), 0);
        step();
        chk("R9 after wrap load", int'(cnt_o), 1);

        // R4: sync ignored with phase loading off
        write_phase(7);
        phase_en_i = 1'b0;
        for (int i = 0; i < 20 && cnt_o != 16'd2; i++) step();
        sync_i = 1'b1; step(); sync_i = 1'b0;
        chk("R4 sync ignored", int'(cnt_o), 3);
        phase_en_i = 1'b1;

        // R5: write alone leaves the count; write with sync uses the old value
        write_phase(5);
        sync_i = 1'b1; phase_wr_i = 1'b1; phase_wdata_i = 16'd3;
        step();
        sync_i = 1'b0; phase_wr_i = 1'b0;
        chk("R5 old phase used", int'(cnt_o), 5);
        step();
        chk("R3 counts up after load", int'(cnt_o), 6);
        sync_i = 1'b1; step(); sync_i = 1'b0;
        chk("R5 new phase on next sync", int'(cnt_o), 3);

        // R10: phase beyond the period
        write_phase(50);
        sync_i = 1'b1; step(); sync_i = 1'b0;
        chk("R10 large phase shown", int'(cnt_o), 50);
        step();
        chk("R10 returns to zero", int'(cnt_o), 0);

        // R6: pass-through of an ignored sync
        sync_sel_i = 2'd1; phase_en_i = 1'b0;
        sync_i = 1'b1; step(); sync_i = 1'b0;
        chk("R6 pass-through pulse", int'(sync_o), 1);
        step();
        chk("R6 pulse is one clock", int'(sync_o), 0);
        phase_en_i = 1'b1;

        // R8: dead band lengths
        sync_sel_i = 2'd0; rise_dly_i = 8'd2; fall_dly_i = 8'd3;
        repeat (30) step();

        // Random phase
        for (int i = 0; i < 20000; i++) begin
            if (i % 2000 == 0) period_i = CNT_W'(2 + $urandom_range(0, 38));
            if (i % 500 == 0) begin
                sync_sel_i = 2'($urandom_range(0, 3));
                cmp_i      = CNT_W'($urandom_range(0, 40));
                rise_dly_i = DB_W'($urandom_range(0, 6));
                fall_dly_i = DB_W'($urandom_range(0, 6));
            end
            sync_i        = ($urandom_range(0, 6) == 0);
            phase_en_i    = ($urandom_range(0, 3) != 0);
            sw_sync_i     = ($urandom_range(0, 9) == 0);
            phase_wr_i    = ($urandom_range(0, 19) == 0);
            phase_wdata_i = CNT_W'($urandom_range(0, 2 * int'(period_i)));
            step();
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miss++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

endmodule